// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit performs bitfield operations on a field that lives in byte-addressed, big-endian memory: unsigned extract, signed extract, insert, change (invert), clear, set, and find-first-one. A request carries a byte base address, a signed bit offset, a field length and a value to insert. The offset may point before the base byte. The unit works out which aligned memory access covers the whole field and reports its address and size. It then takes the loaded data and produces the result value, the N flag source and, for the operations that modify memory, the store data.

Fields may span up to five bytes. The unit picks the smallest access that holds the span: a byte, a word, a longword or a 64-bit quad. It adjusts the address for the three- and five-byte cases so that the access does not straddle more memory than needed. The memory transaction itself is handled outside the unit. Load and store data are right-justified within the access size.

Top module: `bitfield_mem_unit`

## Requirements
- R1: The effective field length is `len_i` modulo 32, with 0 meaning 32. So raw lengths 0 and 32 both give a 32-bit field, and 33 gives a 1-bit field.
- R2: The field starts at absolute bit position `addr_i*8 + ofs_i`, where `ofs_i` is signed and bit 0 of a byte is its most significant bit. The start byte is the floor of that position over 8, and the start bit is the non-negative remainder. Outside the cases of R4, `acc_addr_o` equals the start byte.
- R3: With span = (start bit + length − 1)/8, `acc_size_o` is 0 (byte) for span 0, 1 (word) for span 1, 2 (longword) for spans 2 and 3, and 3 (quad) for span 4.
- R4: For span 2 at an odd start byte, `acc_addr_o` is the start byte minus 1. For span 4, `acc_addr_o` is the start byte rounded down to a multiple of 4.
- R5: Op code 0 (unsigned extract) returns the field zero-extended in `res_o`. Op code 1 (signed extract) returns it sign-extended.
- R6: Op code 2 (insert) writes the low `len` bits of `ins_val_i` into the field in the store data. `res_o` is `ins_val_i` shifted left by (32 − len).
- R7: Op codes 3 (change), 4 (clear) and 5 (set) invert, zero or fill the field bits in the store data. `res_o` is the original field left-justified in 32 bits.
- R8: Op code 6 (find-first-one) returns `ofs_i` plus the index of the first 1 bit of the field, counted from its most significant end. For an all-zero field it returns `ofs_i` plus the length.
- R9: `n_flag_o` is the most significant bit of the original field. For insert, it is bit len−1 of `ins_val_i`.
- R10: `st_we_o` is asserted only for op codes 2 to 5. In `st_data_o`, every bit of the access window outside the field equals the loaded bit.
- R11: `acc_req_o` pulses one cycle after `req_valid_i`. `res_valid_o` and the results appear one cycle after `ld_valid_i`.
- R12: After reset, `acc_req_o`, `res_valid_o` and `st_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start an operation |
| op_i | input | 3 | Operation code (R5–R8) |
| addr_i | input | ADDR_W | Byte base address |
| ofs_i | input | 32 | Signed bit offset |
| len_i | input | 6 | Raw field length |
| ins_val_i | input | 32 | Value for insert |
| acc_req_o | output | 1 | Access address/size valid |
| acc_addr_o | output | ADDR_W | Access byte address |
| acc_size_o | output | 2 | Access size code |
| ld_valid_i | input | 1 | Load data valid |
| ld_data_i | input | 64 | Loaded data, right-justified |
| res_valid_o | output | 1 | Results valid |
| res_o | output | 32 | Operation result |
| n_flag_o | output | 1 | N flag source |
| st_we_o | output | 1 | Store required |
| st_data_o | output | 64 | Store data, right-justified |

## Verification
The access address and size are due one rising edge after `req_valid_i`. The result, N flag, write enable and store data are due one rising edge after `ld_valid_i`. The bench drives each input on a falling edge and samples each output on the next falling edge, so every sample lands on the first cycle after the register that produces it. It sweeps offsets across negative and positive byte boundaries, every raw length 0–33, all four base-address alignments and all seven operations. Memory contents are all-zero, all-one or patterned.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int FRAME_W  = 64;
  localparam int FIELD_W  = 32;
  localparam int OFS_W    = 32;
  localparam int LEN_IN_W = 6;
  localparam int LEN_W    = 6;
  localparam int POS_W    = 6;
  localparam int SPAN_W   = 3;

  typedef enum logic [2:0] {
    OP_EXTU = 3'd0,
    OP_EXTS = 3'd1,
    OP_INS  = 3'd2,
    OP_CHG  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_FFO  = 3'd6,
    OP_RSV  = 3'd7
  } bf_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } bf_size_e;

  typedef struct packed {
    bf_op_e             op;
    bf_size_e           size;
    logic [LEN_W-1:0]   len;
    logic [POS_W-1:0]   bofs;
    logic [OFS_W-1:0]   ofs;
    logic [FIELD_W-1:0] ins_val;
  } bf_ctx_t;
endpackage

// File: rtl/bf_prep.sv
module bf_prep
  import bf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [OFS_W-1:0]    ofs_i,
  input  logic [LEN_IN_W-1:0] len_i,
  output logic [ADDR_W-1:0]   acc_addr_o,
  output bf_size_e            size_o,
  output logic [POS_W-1:0]    bofs_o,
  output logic [LEN_W-1:0]    len_o
);
  logic [ADDR_W-1:0] byte_step;
  logic [ADDR_W-1:0] base;
  logic [2:0]        bit0;
  logic [SPAN_W-1:0] span;

  // length modulo 32, zero selects a full word
  assign len_o     = (len_i[4:0] == 5'd0) ? LEN_W'(32) : LEN_W'(len_i[4:0]);
  // arithmetic shift gives floor division, so negative remainders fold in
  assign byte_step = ADDR_W'($signed(ofs_i) >>> 3);
  assign base      = addr_i + byte_step;
  assign bit0      = ofs_i[2:0];
  assign span      = SPAN_W'((7'(bit0) + 7'(len_o) - 7'd1) >> 3);

  always_comb begin
    acc_addr_o = base;
    size_o     = SZ_BYTE;
    bofs_o     = POS_W'(bit0) + POS_W'(56);
    unique case (span)
      3'd0: begin
        size_o = SZ_BYTE;
        bofs_o = POS_W'(bit0) + POS_W'(56);
      end
      3'd1: begin
        size_o = SZ_WORD;
        bofs_o = POS_W'(bit0) + POS_W'(48);
      end
      3'd2: begin
        size_o = SZ_LONG;
        if (base[0]) begin
          acc_addr_o = base - ADDR_W'(1);
          bofs_o     = POS_W'(bit0) + POS_W'(40);
        end else begin
          bofs_o     = POS_W'(bit0) + POS_W'(32);
        end
      end
      3'd3: begin
        size_o = SZ_LONG;
        bofs_o = POS_W'(bit0) + POS_W'(32);
      end
      default: begin
        size_o     = SZ_QUAD;
        acc_addr_o = {base[ADDR_W-1:2], 2'b00};
        bofs_o     = POS_W'(bit0) + {1'b0, base[1:0], 3'b000};
      end
    endcase
  end
endmodule

// File: rtl/bf_lzc.sv
module bf_lzc #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bf_field.sv
module bf_field
  import bf_pkg::*;
(
  input  bf_op_e              op_i,
  input  logic [FRAME_W-1:0]  frame_i,
  input  logic [POS_W-1:0]    bofs_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [OFS_W-1:0]    ofs_i,
  input  logic [FIELD_W-1:0]  ins_val_i,
  output logic [FRAME_W-1:0]  st_data_o,
  output logic [FIELD_W-1:0]  res_o,
  output logic                n_o,
  output logic                we_o
);
  localparam int CW = $clog2(FIELD_W + 1);

  int                 rs;
  logic [FRAME_W-1:0] fmask;
  logic [FRAME_W-1:0] ins_frame;
  logic [FIELD_W-1:0] msk32;
  logic [FIELD_W-1:0] hi;
  logic [FIELD_W-1:0] lj;
  logic [FIELD_W-1:0] ext_u;
  logic [FIELD_W-1:0] ext_s;
  logic [FIELD_W-1:0] ins_lj;
  logic [CW-1:0]      lz;
  logic [CW-1:0]      ffo_cnt;

  assign rs        = FIELD_W - int'(len_i);
  assign fmask     = ({FRAME_W{1'b1}} << (FRAME_W - int'(len_i))) >> bofs_i;
  assign ins_frame = ({ins_val_i, {FIELD_W{1'b0}}} << rs) >> bofs_i;
  assign msk32     = {FIELD_W{1'b1}} << rs;
  assign hi        = FIELD_W'((frame_i << bofs_i) >> FIELD_W);
  assign lj        = hi & msk32;
  assign ext_u     = lj >> rs;
  assign ext_s     = FIELD_W'($signed(lj) >>> rs);
  assign ins_lj    = ins_val_i << rs;

  bf_lzc #(.W(FIELD_W)) u_lzc (
    .vec_i (lj),
    .cnt_o (lz)
  );

  assign ffo_cnt = (lj == '0) ? CW'(len_i) : lz;

  always_comb begin
    st_data_o = frame_i;
    res_o     = ext_u;
    unique case (op_i)
      OP_EXTS: res_o = ext_s;
      OP_INS: begin
        st_data_o = (frame_i & ~fmask) | ins_frame;
        res_o     = ins_lj;
      end
      OP_CHG: begin
        st_data_o = frame_i ^ fmask;
        res_o     = lj;
      end
      OP_CLR: begin
        st_data_o = frame_i & ~fmask;
        res_o     = lj;
      end
      OP_SET: begin
        st_data_o = frame_i | fmask;
        res_o     = lj;
      end
      OP_FFO:  res_o = ofs_i + FIELD_W'(ffo_cnt);
      default: res_o = ext_u;
    endcase
  end

  assign n_o  = (op_i == OP_INS) ? ins_lj[FIELD_W-1] : lj[FIELD_W-1];
  assign we_o = (op_i == OP_INS) || (op_i == OP_CHG) ||
                (op_i == OP_CLR) || (op_i == OP_SET);
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [2:0]          op_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [OFS_W-1:0]    ofs_i,
  input  logic [LEN_IN_W-1:0] len_i,
  input  logic [FIELD_W-1:0]  ins_val_i,
  output logic                acc_req_o,
  output logic [ADDR_W-1:0]   acc_addr_o,
  output logic [1:0]          acc_size_o,
  input  logic                ld_valid_i,
  input  logic [FRAME_W-1:0]  ld_data_i,
  output logic                res_valid_o,
  output logic [FIELD_W-1:0]  res_o,
  output logic                n_flag_o,
  output logic                st_we_o,
  output logic [FRAME_W-1:0]  st_data_o
);
  logic [ADDR_W-1:0]  p_addr;
  bf_size_e           p_size;
  logic [POS_W-1:0]   p_bofs;
  logic [LEN_W-1:0]   p_len;
  bf_ctx_t            ctx_q;
  logic [FRAME_W-1:0] size_mask;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] f_st;
  logic [FIELD_W-1:0] f_res;
  logic               f_n;
  logic               f_we;

  bf_prep #(.ADDR_W(ADDR_W)) u_prep (
    .addr_i     (addr_i),
    .ofs_i      (ofs_i),
    .len_i      (len_i),
    .acc_addr_o (p_addr),
    .size_o     (p_size),
    .bofs_o     (p_bofs),
    .len_o      (p_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_req_o  <= 1'b0;
      acc_addr_o <= '0;
      acc_size_o <= 2'd0;
      ctx_q      <= '0;
    end else begin
      acc_req_o <= req_valid_i;
      if (req_valid_i) begin
        acc_addr_o    <= p_addr;
        acc_size_o    <= p_size;
        ctx_q.op      <= bf_op_e'(op_i);
        ctx_q.size    <= p_size;
        ctx_q.len     <= p_len;
        ctx_q.bofs    <= p_bofs;
        ctx_q.ofs     <= ofs_i;
        ctx_q.ins_val <= ins_val_i;
      end
    end
  end

  always_comb begin
    unique case (ctx_q.size)
      SZ_BYTE: size_mask = FRAME_W'(64'h0000_0000_0000_00ff);
      SZ_WORD: size_mask = FRAME_W'(64'h0000_0000_0000_ffff);
      SZ_LONG: size_mask = FRAME_W'(64'h0000_0000_ffff_ffff);
      default: size_mask = {FRAME_W{1'b1}};
    endcase
  end

  assign frame = ld_data_i & size_mask;

  bf_field u_field (
    .op_i      (ctx_q.op),
    .frame_i   (frame),
    .bofs_i    (ctx_q.bofs),
    .len_i     (ctx_q.len),
    .ofs_i     (ctx_q.ofs),
    .ins_val_i (ctx_q.ins_val),
    .st_data_o (f_st),
    .res_o     (f_res),
    .n_o       (f_n),
    .we_o      (f_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
      n_flag_o    <= 1'b0;
      st_we_o     <= 1'b0;
      st_data_o   <= '0;
    end else begin
      res_valid_o <= ld_valid_i;
      st_we_o     <= ld_valid_i & f_we;
      if (ld_valid_i) begin
        res_o     <= f_res;
        n_flag_o  <= f_n;
        st_data_o <= f_st;
      end
    end
  end

  // R11
  acc_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> acc_req_o);

  // R11
  res_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> res_valid_o);

  // R10
  we_modify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_o && !acc_req_o) |-> (res_valid_o &&
      (ctx_q.op == OP_INS || ctx_q.op == OP_CHG ||
       ctx_q.op == OP_CLR || ctx_q.op == OP_SET)));

  // R4
  quad_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_o && acc_size_o == 2'd3) |-> (acc_addr_o[1:0] == 2'b00));

  // R1
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_o |-> (ctx_q.len >= LEN_W'(1) && ctx_q.len <= LEN_W'(32)));

  // R8
  ffo_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !acc_req_o && ctx_q.op == OP_FFO) |->
      ((res_o - ctx_q.ofs) <= FIELD_W'(ctx_q.len)));
endmodule

// File: tb/bitfield_mem_unit_tb.sv
`timescale 1ns/1ps
module bitfield_mem_unit_tb;
  localparam int ADDR_W = 32;
  localparam longint BASE = 64'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] addr = '0;
  logic [31:0] ofs = '0;
  logic [5:0]  len_raw = '0;
  logic [31:0] ins_val = '0;
  logic        acc_req;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic        ld_valid = 1'b0;
  logic [63:0] ld_data = '0;
  logic        res_valid;
  logic [31:0] res;
  logic        n_flag;
  logic        st_we;
  logic [63:0] st_data;

  int total = 0;
  int bad = 0;
  int pat = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bitfield_mem_unit #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .op_i        (op),
    .addr_i      (addr),
    .ofs_i       (ofs),
    .len_i       (len_raw),
    .ins_val_i   (ins_val),
    .acc_req_o   (acc_req),
    .acc_addr_o  (acc_addr),
    .acc_size_o  (acc_size),
    .ld_valid_i  (ld_valid),
    .ld_data_i   (ld_data),
    .res_valid_o (res_valid),
    .res_o       (res),
    .n_flag_o    (n_flag),
    .st_we_o     (st_we),
    .st_data_o   (st_data)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(longint a);
    if (pat == 0) return 8'h00;
    if (pat == 1) return 8'hff;
    return 8'((a * 29) ^ (a >> 2) ^ (longint'(pat) * 7));
  endfunction

  function automatic logic membit(longint p);
    logic [7:0] b;
    b = mb(p >>> 3);
    return b[7 - int'(p & 7)];
  endfunction

  task automatic run(int o, int lr, int a, int opc, logic [31:0] iv);
    int len, span, b0, nb, first;
    longint abs0, fa, ea;
    logic [1:0]  sz;
    logic [63:0] ld, exp_st;
    logic [31:0] fv, exp_res;
    logic        exp_n, exp_we, bt;
    string       atag, rtag, stag;

    len  = (lr % 32 == 0) ? 32 : lr % 32;
    abs0 = (BASE + a) * 8 + o;
    fa   = abs0 >>> 3;
    b0   = int'(abs0 & 7);
    span = (b0 + len - 1) / 8;
    ea   = fa;
    atag = "R2";
    case (span)
      0: begin sz = 2'd0; nb = 1; end
      1: begin sz = 2'd1; nb = 2; end
      2: begin
        sz = 2'd2; nb = 4;
        if (fa % 2 == 1) begin ea = fa - 1; atag = "R4"; end
      end
      3: begin sz = 2'd2; nb = 4; end
      default: begin sz = 2'd3; nb = 8; ea = fa & ~longint'(3); atag = "R4"; end
    endcase

    ld = '0;
    for (int k = 0; k < nb; k++) ld = (ld << 8) | 64'(mb(ea + k));

    fv = '0;
    first = len;
    for (int i = 0; i < len; i++) begin
      bt = membit(abs0 + i);
      fv = (fv << 1) | 32'(bt);
      if (bt && first == len) first = i;
    end

    exp_we = (opc >= 2 && opc <= 5);
    exp_n  = (opc == 2) ? iv[len-1] : fv[len-1];
    case (opc)
      0: begin exp_res = fv; rtag = "R5"; end
      1: begin
        exp_res = fv;
        if (len < 32 && fv[len-1]) exp_res = fv | (32'hffff_ffff << len);
        rtag = "R5";
      end
      2: begin exp_res = iv << (32 - len); rtag = "R6"; end
      6: begin exp_res = 32'(o) + 32'(first); rtag = "R8"; end
      default: begin exp_res = fv << (32 - len); rtag = "R7"; end
    endcase
    if (lr == 0 || lr >= 32) rtag = "R1";
    stag = (opc == 2) ? "R6 R10" : "R7 R10";

    exp_st = '0;
    for (int j = 0; j < nb * 8; j++) begin
      longint p, rel;
      p   = ea * 8 + j;
      rel = p - abs0;
      bt  = membit(p);
      if (rel >= 0 && rel < len) begin
        case (opc)
          2: bt = iv[len - 1 - int'(rel)];
          3: bt = ~bt;
          4: bt = 1'b0;
          5: bt = 1'b1;
          default: ;
        endcase
      end
      exp_st[nb * 8 - 1 - j] = bt;
    end

    @(negedge clk);
    req_valid = 1'b1;
    op        = 3'(opc);
    addr      = 32'(BASE + a);
    ofs       = 32'(o);
    len_raw   = 6'(lr);
    ins_val   = iv;
    @(negedge clk);
    chk("R11 acc_req", 64'(acc_req), 64'd1);
    chk(atag, 64'(acc_addr), 64'(ea[31:0]));
    chk("R3 size", 64'(acc_size), 64'(sz));
    req_valid = 1'b0;
    ld_valid  = 1'b1;
    ld_data   = ld;
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R11 res_valid", 64'(res_valid), 64'd1);
    chk("R11 acc_req pulse", 64'(acc_req), 64'd0);
    chk(rtag, 64'(res), 64'(exp_res));
    chk("R9 n", 64'(n_flag), 64'(exp_n));
    chk("R10 we", 64'(st_we), 64'(exp_we));
    if (exp_we) chk(stag, st_data, exp_st);
  endtask

  initial begin
    int iter;
    iter = 0;
    #1;
    chk("R12 acc_req in reset", 64'(acc_req), 64'd0);
    chk("R12 res_valid in reset", 64'(res_valid), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 acc_req", 64'(acc_req), 64'd0);
    chk("R12 res_valid", 64'(res_valid), 64'd0);
    chk("R12 st_we", 64'(st_we), 64'd0);
    for (int o = -12; o <= 19; o++) begin
      for (int lr = 0; lr <= 33; lr++) begin
        for (int a = 0; a < 4; a++) begin
          logic [31:0] iv;
          pat = iter % 5;
          iv  = 32'ha5c3_96e1 ^ (32'(iter) * 32'h9e37_79b9);
          iter++;
          for (int opc = 0; opc < 7; opc++) run(o, lr, a, opc, iv);
        end
      end
    end
    @(negedge clk);
    chk("R11 res_valid idle", 64'(res_valid), 64'd0);
    chk("R10 we idle", 64'(st_we), 64'd0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R11 watchdog act=timeout exp=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule